// File: doc/BRIEF.md
# Level-1 Accept Pipeline and Derandomizer

Hit data from every bunch crossing enters a fixed-length shift pipeline clocked at the crossing rate. A level-1 accept selects a window of three adjacent crossings from the far end of that pipeline: the crossing just before the selected one, the selected crossing, and the one after it. Those three words are written one per clock into a dual-clock derandomizing FIFO. Each entry carries the hit word, the crossing's position in the window, the low bits of the bunch number and an event number.

A downstream consumer drains the FIFO on its own readout clock through a valid/ready stream. The bunch number counts crossings since the last bunch counter reset. The event number counts accepts since the last event counter reset. An accept that cannot be stored in full is discarded as a whole and sets a sticky overflow flag.

Top module: `l1_readout_top`

## Requirements
- R1: After reset of both domains `rd_valid_o` is 0 and `ovf_o` is 0.
- R2: An accept sampled at write-clock edge m produces three entries, in order, whose hit fields hold the words sampled at edges m-PIPE_DEPTH, m-PIPE_DEPTH+1 and m-PIPE_DEPTH+2 (selected latency PIPE_DEPTH-1). With the defaults this is m-128, m-127 and m-126.
- R3: The crossing-index field `rd_data_o[HIT_W+1:HIT_W]` is 0, 1 and 2 for the earlier, selected and later crossing respectively.
- R4: Field `rd_data_o[HIT_W+2+BC_TAG_W-1:HIT_W+2]` holds the low BC_TAG_W bits of the accept cycle's bunch number. The bunch number is 0 in a cycle with `bcr_i` high and otherwise is one more than in the previous cycle.
- R5: The top EVT_W bits of `rd_data_o` hold the event number. That number is 0 for an accept coinciding with `ecr_i`, and otherwise counts every accept, including dropped ones, since the last `ecr_i`.
- R6: An accept arriving while fewer than three FIFO entries are free is dropped: no entry is written, and `ovf_o` rises one cycle later.
- R7: An accept arriving 1, 2 or 3 cycles after a stored accept is dropped and sets `ovf_o`. An accept 4 or more cycles later is stored.
- R8: `ovf_o` stays 1 until reset.
- R9: Entries leave in write order. While `rd_valid_o` is high and `rd_ready_i` is low, `rd_valid_o` stays high and `rd_data_o` does not change.
- R10: Write and read sides run on unrelated clocks, and pointers pass between them in Gray code that changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset, crossing domain |
| hit_i | input | HIT_W | Hit word of the current crossing |
| bcr_i | input | 1 | Bunch counter reset |
| ecr_i | input | 1 | Event counter reset |
| l1a_i | input | 1 | Level-1 accept strobe |
| rclk | input | 1 | Readout clock |
| rrst_n | input | 1 | Synchronous active-low reset, readout domain |
| rd_valid_o | output | 1 | Entry available |
| rd_ready_i | input | 1 | Consumer takes the entry |
| rd_data_o | output | HIT_W+6+EVT_W | {event, bunch tag, index, hit} |
| ovf_o | output | 1 | Sticky overflow |

## Verification
An accept can fall in the same cycle as a bunch counter reset or an event counter reset. In that case the tag must take the reset value and not the running count. The bench places bcr and ecr pulses on some accept edges and on some idle edges, and compares every drained field with counters it keeps itself. A second collision is an accept that meets a busy write sequencer or a nearly full FIFO. The bench provokes it with accepts spaced 2, 3 and 4 cycles apart, and with 43 accepts against a stalled reader. It then judges the overflow flag and the exact number of entries drained.

// File: rtl/l1_readout_pkg.sv
package l1_readout_pkg;
    localparam int XING_W = 2;
    typedef enum logic [XING_W-1:0] {
        XING_EARLY = 2'd0,
        XING_SEL   = 2'd1,
        XING_LATE  = 2'd2
    } xing_e;
endpackage

// File: rtl/l1_pipe.sv
module l1_pipe #(
    parameter int HIT_W = 16,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HIT_W-1:0] hit,
    output logic [HIT_W-1:0] tap_early,
    output logic [HIT_W-1:0] tap_sel,
    output logic [HIT_W-1:0] tap_late
);
    logic [DEPTH-1:0][HIT_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[DEPTH-2:0], hit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign tap_early = sr_q[DEPTH-1];
    assign tap_sel   = sr_q[DEPTH-2];
    assign tap_late  = sr_q[DEPTH-3];
endmodule

// File: rtl/l1_capture.sv
module l1_capture
    import l1_readout_pkg::*;
#(
    parameter int HIT_W    = 16,
    parameter int BC_W     = 12,
    parameter int BC_TAG_W = 4,
    parameter int EVT_W    = 8,
    parameter int ENTRY_W  = EVT_W + BC_TAG_W + XING_W + HIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bcr,
    input  logic               ecr,
    input  logic               l1a,
    input  logic [HIT_W-1:0]   w_early,
    input  logic [HIT_W-1:0]   w_sel,
    input  logic [HIT_W-1:0]   w_late,
    input  logic               room3,
    output logic               wr_en,
    output logic [ENTRY_W-1:0] wr_data,
    output logic               ovf
);
    typedef struct packed {
        logic [BC_W-1:0]         bc;
        logic [EVT_W-1:0]        evt;
        logic [1:0]              seq;
        logic [2:0][HIT_W-1:0]   win;
        logic [BC_TAG_W-1:0]     bc_tag;
        logic [EVT_W-1:0]        evt_tag;
        logic                    ovf;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [BC_W-1:0]   bc_now;
    logic [EVT_W-1:0]  evt_now;
    logic              busy, take;
    logic [XING_W-1:0] wr_idx;

    always_comb begin
        cap_d   = cap_q;
        bc_now  = bcr ? '0 : cap_q.bc;
        evt_now = ecr ? '0 : cap_q.evt;
        cap_d.bc  = bc_now + BC_W'(1);
        cap_d.evt = l1a ? evt_now + EVT_W'(1) : evt_now;
        busy = (cap_q.seq != 2'd0);
        take = l1a && !busy && room3;
        if (busy) cap_d.seq = (cap_q.seq == 2'd3) ? 2'd0 : cap_q.seq + 2'd1;
        if (take) begin
            cap_d.seq     = 2'd1;
            cap_d.win     = {w_late, w_sel, w_early};
            cap_d.bc_tag  = bc_now[BC_TAG_W-1:0];
            cap_d.evt_tag = evt_now;
        end
        if (l1a && !take) cap_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign wr_idx  = cap_q.seq - 2'd1;
    assign wr_en   = busy;
    assign wr_data = {cap_q.evt_tag, cap_q.bc_tag, wr_idx, cap_q.win[wr_idx]};
    assign ovf     = cap_q.ovf;

    // R3: a window is written as three back-to-back entries
    a_r3_window_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == XING_EARLY) |=> (wr_en && wr_idx == XING_SEL));
    a_r3_window_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == XING_SEL) |=> (wr_en && wr_idx == XING_LATE));
    // R8: overflow never clears outside reset
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R6: accept without room raises overflow
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a && !room3) |=> ovf);
endmodule

// File: rtl/l1_derand.sv
module l1_derand #(
    parameter int W     = 30,
    parameter int DEPTH = 128,
    parameter int SYNC  = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         room3,
    input  logic         rclk,
    input  logic         rrst_n,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    typedef struct packed {
        logic [PW-1:0]            bin;
        logic [PW-1:0]            gray;
        logic [SYNC-1:0][PW-1:0]  peer;
    } side_t;

    side_t wr_d, wr_q, rd_d, rd_q;
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] used;
    logic          full, pop;

    // write domain
    always_comb begin
        wr_d      = wr_q;
        wr_d.bin  = wr_en ? wr_q.bin + PW'(1) : wr_q.bin;
        wr_d.gray = to_gray(wr_d.bin);
        wr_d.peer = {wr_q.peer[SYNC-2:0], rd_q.gray};
        used      = wr_q.bin - from_gray(wr_q.peer[SYNC-1]);
        room3     = (used <= PW'(DEPTH - 3));
        full      = (used == PW'(DEPTH));
    end

    always_ff @(posedge wclk) begin
        if (!wrst_n) wr_q <= '0;
        else         wr_q <= wr_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_en) mem[wr_q.bin[AW-1:0]] <= wr_data;
    end

    // read domain
    always_comb begin
        rd_d      = rd_q;
        rd_valid  = (rd_q.gray != rd_q.peer[SYNC-1]);
        pop       = rd_valid && rd_ready;
        rd_d.bin  = pop ? rd_q.bin + PW'(1) : rd_q.bin;
        rd_d.gray = to_gray(rd_d.bin);
        rd_d.peer = {rd_q.peer[SYNC-2:0], wr_q.gray};
    end

    always_ff @(posedge rclk) begin
        if (!rrst_n) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data = mem[rd_q.bin[AW-1:0]];

    // R6: the capture side never writes into a full store
    a_r6_no_write_full: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> !full);
    // R9: a stalled entry holds
    a_r9_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R10: crossing pointers move by one Gray step at most
    a_r10_wgray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
        $onehot0(wr_q.gray ^ $past(wr_q.gray)));
    a_r10_rgray_step: assert property (@(posedge rclk) disable iff (!rrst_n)
        $onehot0(rd_q.gray ^ $past(rd_q.gray)));
endmodule

// File: rtl/l1_readout_top.sv
module l1_readout_top
    import l1_readout_pkg::*;
#(
    parameter int HIT_W       = 16,
    parameter int PIPE_DEPTH  = 128,
    parameter int FIFO_DEPTH  = 128,
    parameter int BC_W        = 12,
    parameter int BC_TAG_W    = 4,
    parameter int EVT_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ENTRY_W    = EVT_W + BC_TAG_W + XING_W + HIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HIT_W-1:0]   hit_i,
    input  logic               bcr_i,
    input  logic               ecr_i,
    input  logic               l1a_i,
    input  logic               rclk,
    input  logic               rrst_n,
    output logic               rd_valid_o,
    input  logic               rd_ready_i,
    output logic [ENTRY_W-1:0] rd_data_o,
    output logic               ovf_o
);
    generate
        if ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0 || FIFO_DEPTH < 4 ||
            SYNC_STAGES < 2 || PIPE_DEPTH < 3 || BC_TAG_W > BC_W) begin : g_bad_cfg
            $error("l1_readout_top: unsupported parameter set");
        end
    endgenerate

    logic [HIT_W-1:0]   t_early, t_sel, t_late;
    logic               room3, wr_en;
    logic [ENTRY_W-1:0] wr_data;

    l1_pipe #(.HIT_W(HIT_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .hit(hit_i),
        .tap_early(t_early), .tap_sel(t_sel), .tap_late(t_late)
    );

    l1_capture #(
        .HIT_W(HIT_W), .BC_W(BC_W), .BC_TAG_W(BC_TAG_W),
        .EVT_W(EVT_W), .ENTRY_W(ENTRY_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .bcr(bcr_i), .ecr(ecr_i), .l1a(l1a_i),
        .w_early(t_early), .w_sel(t_sel), .w_late(t_late),
        .room3(room3), .wr_en(wr_en), .wr_data(wr_data), .ovf(ovf_o)
    );

    l1_derand #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH), .SYNC(SYNC_STAGES)) u_fifo (
        .wclk(clk), .wrst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .room3(room3), .rclk(rclk), .rrst_n(rrst_n),
        .rd_valid(rd_valid_o), .rd_ready(rd_ready_i), .rd_data(rd_data_o)
    );
endmodule

// File: tb/sim_l1_readout_top.sv
module sim_l1_readout_top;
    localparam int HW = 16, PD = 128, FD = 128, EW = 8, TW = 4;
    localparam int ENW = EW + TW + 2 + HW;

    logic clk = 1'b0, rclk = 1'b0;
    always #5 clk = ~clk;
    always #7 rclk = ~rclk;

    logic rst_n, rrst_n, bcr_i, ecr_i, l1a_i, rd_ready_i, rd_valid_o, ovf_o;
    logic [HW-1:0]  hit_i;
    logic [ENW-1:0] rd_data_o;

    l1_readout_top u0 (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .bcr_i(bcr_i), .ecr_i(ecr_i),
        .l1a_i(l1a_i), .rclk(rclk), .rrst_n(rrst_n), .rd_valid_o(rd_valid_o),
        .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o), .ovf_o(ovf_o)
    );

    int checks = 0, fails = 0, cyc = 0;
    int bm, em, since, nexp, npop;
    bit done = 0;
    logic [HW-1:0]  hist [256];
    logic [ENW-1:0] expq [512];

    function automatic logic [HW-1:0] hitf(input int n);
        return HW'(n * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model, crossing domain
    always @(posedge clk) begin
        int cb, ce;
        cyc = cyc + 1;
        hist[cyc % 256] = hit_i;
        if (!rst_n) begin
            bm = 0; em = 0; since = 50; nexp = 0; npop = 0;
        end else begin
            cb = bcr_i ? 0 : bm;
            bm = (cb + 1) % 4096;
            ce = ecr_i ? 0 : em;
            since = (since < 50) ? since + 1 : 50;
            if (l1a_i) begin
                em = (ce + 1) % 256;
                if (since >= 4 && (FD - (nexp - npop)) >= 3) begin
                    for (int k = 0; k < 3; k++) begin
                        expq[nexp % 512] = {EW'(ce), TW'(cb), 2'(k), hist[(cyc - PD + k) % 256]};
                        nexp++;
                    end
                    since = 0;
                end
            end else em = ce;
        end
    end

    initial begin
        hit_i = '0;
        forever begin
            @(negedge clk);
            hit_i = hitf(cyc + 1);
        end
    end

    task automatic tick(input logic l, input logic b, input logic e);
        @(negedge clk);
        l1a_i = l; bcr_i = b; ecr_i = e;
    endtask

    task automatic idle(input int n);
        repeat (n) tick(1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rrst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1; rrst_n = 1'b1;
    endtask

    task automatic drain(input int want, input string req);
        int got = 0, gap = 0;
        while (gap < 60) begin
            @(negedge rclk);
            if (rd_valid_o) begin
                chk({req, " entry"}, 64'(rd_data_o), 64'(expq[npop % 512]));
                rd_ready_i = 1'b1;
                npop++; got++; gap = 0;
            end else begin
                rd_ready_i = 1'b0;
                gap++;
            end
        end
        rd_ready_i = 1'b0;
        chk({req, " entry count"}, 64'(got), 64'(want));
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [ENW-1:0] snap;
        l1a_i = 0; bcr_i = 0; ecr_i = 0; rd_ready_i = 0;
        do_reset();
        @(negedge rclk);
        chk("R1 valid after reset", 64'(rd_valid_o), 0);
        chk("R1 ovf after reset", 64'(ovf_o), 0);

        // window, index, bunch and event tags, including resets on accept cycles
        idle(140);
        for (int i = 0; i < 20; i++) begin
            tick(1'b1, (i % 5) == 2, i == 7);
            tick(1'b0, (i % 3) == 0, i == 12);
            idle(2 + (i % 4));
        end
        idle(10);
        chk("R7 ovf with legal spacing", 64'(ovf_o), 0);
        repeat (4) @(negedge rclk);
        snap = rd_data_o;
        repeat (3) @(negedge rclk);
        chk("R9 valid held while stalled", 64'(rd_valid_o), 1);
        chk("R9 data held while stalled", 64'(rd_data_o), 64'(snap));
        drain(60, "R2 R3 R4 R5 R9 R10");

        // accept spacing against the busy write sequencer
        tick(1, 0, 0); tick(0, 0, 0); tick(1, 0, 0); tick(0, 0, 0);
        tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0); tick(1, 0, 0);
        tick(1, 0, 0);
        idle(6);
        chk("R7 ovf after close accepts", 64'(ovf_o), 1);
        drain(9, "R7 spacing 2/3/4");
        idle(50);
        chk("R8 ovf still set", 64'(ovf_o), 1);
        do_reset();
        @(negedge clk);
        chk("R8 ovf cleared by reset", 64'(ovf_o), 0);
        chk("R1 valid after second reset", 64'(rd_valid_o), 0);

        // fill against a stalled reader
        idle(140);
        for (int i = 0; i < 42; i++) begin
            tick(1, 0, 0);
            idle(4);
        end
        chk("R6 ovf at 126 entries", 64'(ovf_o), 0);
        tick(1, 0, 0);
        idle(3);
        chk("R6 ovf on accept without room", 64'(ovf_o), 1);
        drain(126, "R6 full");
        idle(20);
        tick(1, 0, 0);
        idle(10);
        drain(3, "R6 after drain");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule